// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside the storage array of a dual-clock FIFO and owns the two programmable thresholds that decide when the FIFO is nearly drained or nearly filled. It keeps an almost-empty offset (n) and an almost-full offset (m). From the FIFO occupancy and a mode bit, it produces two active-low warning flags. The block does not store FIFO data and does not synchronise pointers: the occupancy count comes in as an input.

Both offsets are reached through one shared path, and the slot used is chosen by a fixed alternating sequence. A configuration write happens when `cfg_sel` and `wr_en` are both high on a `wr_clk` edge. The write side has a two-state machine: `SLOT_AE` moves to `SLOT_AF` on a configuration write, and `SLOT_AF` moves back to `SLOT_AE` on the next one. A readback happens when `cfg_sel` and `rd_en` are both high on a `rd_clk` edge. The read side has its own machine with the same two states and the same transitions, which advances only on readbacks. Reset puts both machines in `SLOT_AE`. The offset field is 12 bits wide when `DEPTH` is at most 1024 and 16 bits wide for deeper FIFOs.

The almost-empty threshold depends on the output style. In standard mode (`mode_fwft`=0) it is n words. In first-word-fall-through mode (`mode_fwft`=1) it is n+1 words, because the FIFO holds one extra word in its output stage.

Top module: `prog_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises: both offsets equal `DEF_OFS` (7), both sequence machines are in `SLOT_AE`, and `rd_word` is 0.
- R2: A configuration write (`cfg_sel`=1 and `wr_en`=1 at a `wr_clk` rising edge) stores `din[OFS_W-1:0]` in the slot the write machine points to. Successive writes fill the almost-empty slot, then the almost-full slot, then the almost-empty slot again.
- R3: On a `wr_clk` edge where `wr_en` is high without `cfg_sel`, or `cfg_sel` is high without `wr_en`, neither offset changes and the write machine does not advance.
- R4: A readback (`cfg_sel`=1 and `rd_en`=1 at a `rd_clk` rising edge) loads `rd_word` with the offset of the slot the read machine points to, zero-extended, and then advances the read machine. The read machine's order is almost-empty, almost-full, almost-empty, and it does not depend on the write machine.
- R5: `rd_word` holds its value on every `rd_clk` edge that is not a readback.
- R6: With `mode_fwft`=0, `almost_empty_n` is 0 exactly when `fill_level` <= n.
- R7: With `mode_fwft`=1, `almost_empty_n` is 0 exactly when `fill_level` <= n+1.
- R8: `almost_full_n` is 0 exactly when `DEPTH - fill_level` <= m.
- R9: With `DEPTH`=256 the offset field is 12 bits wide. `din` bits above bit 11 are discarded on a write and read back as 0.
- R10: Both flags follow `fill_level`, `mode_fwft` and the stored offsets combinationally, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 1 | Selects offset access instead of data access |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| din | input | DATA_W | Write data; the low OFS_W bits carry an offset |
| mode_fwft | input | 1 | 1 = first-word-fall-through, 0 = standard |
| fill_level | input | CNT_W | Words currently stored in the FIFO |
| rd_word | output | DATA_W | Offset returned by a readback, zero-extended |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
A wrong write-machine state puts the next configuration write into the wrong slot. This shows on the first readback of that slot, and it also moves one flag threshold, which shows as soon as `fill_level` sweeps across the threshold. A wrong read-machine state returns the other offset on the very next readback. An offset that changed when it should not have shows as a flag edge at the wrong occupancy in the sweep of the next test, and as a mismatched value on its next readback.

// File: rtl/pf_pkg.sv
package pf_pkg;

    // Which offset register a sequence machine points at.
    typedef enum logic {
        SLOT_AE = 1'b0,
        SLOT_AF = 1'b1
    } slot_e;

    // Width of an offset field for a given FIFO depth.
    function automatic int ofs_width(input int depth);
        return (depth > 1024) ? 16 : 12;
    endfunction

endpackage

// File: rtl/offset_store.sv
module offset_store
    import pf_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int DEF_OFS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [OFS_W-1:0] load_val,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output slot_e            slot
);
    localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(DEF_OFS);

    slot_e slot_nxt;

    // Next-state logic: alternate on every configuration write.
    always_comb begin
        slot_nxt = slot;
        if (load_en) begin
            unique case (slot)
                SLOT_AE: slot_nxt = SLOT_AF;
                SLOT_AF: slot_nxt = SLOT_AE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot <= SLOT_AE;
        else        slot <= slot_nxt;
    end

    // Offset registers: written only in the slot the machine points at.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= DEF_VAL;
            af_ofs <= DEF_VAL;
        end else if (load_en) begin
            unique case (slot)
                SLOT_AE: ae_ofs <= load_val;
                SLOT_AF: af_ofs <= load_val;
            endcase
        end
    end

    // R2: every configuration write moves the machine to the other slot
    assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> slot != $past(slot));

    // R2: a write in the almost-empty slot lands in the almost-empty register
    assert_ae_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && slot == SLOT_AE) |=> (ae_ofs == $past(load_val) && $stable(af_ofs)));

    // R3: without a configuration write nothing in the write domain moves
    assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(slot)));

endmodule

// File: rtl/offset_readback.sv
module offset_readback
    import pf_pkg::*;
#(
    parameter int OFS_W  = 12,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_load,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    output logic [DATA_W-1:0] rd_word
);
    slot_e slot;
    slot_e slot_nxt;
    logic [OFS_W-1:0] pick;

    // Next-state logic: alternate on every readback.
    always_comb begin
        slot_nxt = slot;
        if (rd_load) begin
            unique case (slot)
                SLOT_AE: slot_nxt = SLOT_AF;
                SLOT_AF: slot_nxt = SLOT_AE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot <= SLOT_AE;
        else        slot <= slot_nxt;
    end

    // Select the offset of the current slot.
    always_comb begin
        unique case (slot)
            SLOT_AE: pick = ae_ofs;
            SLOT_AF: pick = af_ofs;
        endcase
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_word <= '0;
        else if (rd_load) rd_word <= DATA_W'(pick);
    end

    // R4: a readback in the almost-empty slot returns the almost-empty offset
    assert_readback_ae_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && slot == SLOT_AE) |=> rd_word == DATA_W'($past(ae_ofs)));

    // R4: a readback in the almost-full slot returns the almost-full offset
    assert_readback_af_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && slot == SLOT_AF) |=> rd_word == DATA_W'($past(af_ofs)));

    // R5: the output register holds between readbacks
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_load |=> $stable(rd_word));

endmodule

// File: rtl/flag_compare.sv
module flag_compare #(
    parameter int DEPTH = 256,
    parameter int OFS_W = 12,
    parameter int CNT_W = 9
) (
    input  logic [CNT_W-1:0] fill_level,
    input  logic             mode_fwft,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             almost_empty_n,
    output logic             almost_full_n
);
    localparam int CMP_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 2;

    logic [CMP_W-1:0] fill_x;
    logic [CMP_W-1:0] free_x;
    logic [CMP_W-1:0] ae_thr;
    logic [CMP_W-1:0] af_thr;

    always_comb begin
        fill_x = CMP_W'(fill_level);
        free_x = CMP_W'(DEPTH) - fill_x;
        // First-word-fall-through keeps one more word in the output stage.
        ae_thr = CMP_W'(ae_ofs) + CMP_W'(mode_fwft);
        af_thr = CMP_W'(af_ofs);
        almost_empty_n = !(fill_x <= ae_thr);
        almost_full_n  = !(free_x <= af_thr);
    end

endmodule

// File: rtl/prog_flag_unit.sv
module prog_flag_unit
    import pf_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int DATA_W  = 18,
    parameter int DEF_OFS = 7,
    localparam int OFS_W  = pf_pkg::ofs_width(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] din,
    input  logic              mode_fwft,
    input  logic [CNT_W-1:0]  fill_level,
    output logic [DATA_W-1:0] rd_word,
    output logic              almost_empty_n,
    output logic              almost_full_n
);
    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;
    slot_e            wr_slot;
    logic             wr_load;
    logic             rd_load;

    assign wr_load = cfg_sel && wr_en;
    assign rd_load = cfg_sel && rd_en;

    // Bits of din above the offset field are not stored.
    generate
        if (DATA_W > OFS_W) begin : g_drop_hi
            logic unused_din_hi;
            assign unused_din_hi = ^din[DATA_W-1:OFS_W];
        end
    endgenerate

    offset_store #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) store_i (
        .clk      (wr_clk),
        .rst_n    (rst_n),
        .load_en  (wr_load),
        .load_val (din[OFS_W-1:0]),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs),
        .slot     (wr_slot)
    );

    offset_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) rdbk_i (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .rd_load (rd_load),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .rd_word (rd_word)
    );

    flag_compare #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) cmp_i (
        .fill_level     (fill_level),
        .mode_fwft      (mode_fwft),
        .ae_ofs         (ae_ofs),
        .af_ofs         (af_ofs),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n)
    );

    // R6: an empty FIFO is always almost empty
    assert_empty_flag_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fill_level == '0) |-> !almost_empty_n);

    // R8: a full FIFO is always almost full
    assert_full_flag_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (fill_level == CNT_W'(DEPTH)) |-> !almost_full_n);

    // R1: the write machine leaves reset pointing at the almost-empty slot
    assert_reset_slot_R1: assert property (@(posedge wr_clk)
        $rose(rst_n) |-> wr_slot == SLOT_AE);

endmodule

// File: tb/prog_flag_unit_tb_top.sv
module prog_flag_unit_tb_top;
    localparam int DEPTH  = 256;
    localparam int DATA_W = 18;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam time TCK   = 8ns;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              rst_n;
    logic              cfg_sel, wr_en, rd_en, mode_fwft;
    logic [DATA_W-1:0] din;
    logic [CNT_W-1:0]  fill_level;
    logic [DATA_W-1:0] rd_word;
    logic              almost_empty_n, almost_full_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(TCK/2) begin
        wr_clk = ~wr_clk;
        rd_clk = ~rd_clk;
    end

    prog_flag_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEF_OFS(7)) dut_i (
        .wr_clk, .rd_clk, .rst_n, .cfg_sel, .wr_en, .rd_en, .din,
        .mode_fwft, .fill_level, .rd_word, .almost_empty_n, .almost_full_n
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        rst_n = 1'b0; cfg_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        din = '0; mode_fwft = 1'b0; fill_level = '0;
        repeat (2) @(negedge wr_clk);
        rst_n = 1'b1;
        @(negedge wr_clk);
    endtask

    task automatic cfg_write(input logic [DATA_W-1:0] v);
        @(negedge wr_clk);
        cfg_sel = 1'b1; wr_en = 1'b1; din = v;
        @(negedge wr_clk);
        cfg_sel = 1'b0; wr_en = 1'b0;
    endtask

    // Readback: inputs set at a falling edge, result sampled at the next falling edge.
    task automatic cfg_read(input string tag, input int exp);
        @(negedge rd_clk);
        cfg_sel = 1'b1; rd_en = 1'b1;
        @(negedge rd_clk);
        cfg_sel = 1'b0; rd_en = 1'b0;
        check(tag, int'(rd_word), exp);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 rd_word after reset", int'(rd_word), 0);
        fill_level = CNT_W'(7); #1;
        check("R1 default n: ae at 7 words", int'(almost_empty_n), 0);
        fill_level = CNT_W'(8); #1;
        check("R1 default n: no ae at 8 words", int'(almost_empty_n), 1);
        fill_level = CNT_W'(DEPTH - 7); #1;
        check("R1 default m: af at 7 free", int'(almost_full_n), 0);
        fill_level = CNT_W'(DEPTH - 8); #1;
        check("R1 default m: no af at 8 free", int'(almost_full_n), 1);
        cfg_read("R1 R4 first readback is n", 7);
        cfg_read("R1 R4 second readback is m", 7);
        do_reset();
    endtask

    task automatic t_load_readback();
        cfg_write(18'd5);
        cfg_write(18'd9);
        cfg_read("R2 R4 slot ae holds 5", 5);
        cfg_read("R2 R4 slot af holds 9", 9);
        cfg_read("R4 read order wraps to ae", 5);
    endtask

    task automatic t_ignored_strobes();
        // Read machine now points at the almost-full slot; write machine at ae.
        @(negedge wr_clk);
        wr_en = 1'b1; din = 18'd100;
        @(negedge wr_clk);
        wr_en = 1'b0; cfg_sel = 1'b1; din = 18'd200;
        @(negedge wr_clk);
        cfg_sel = 1'b0; rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        check("R5 rd_word holds without cfg_sel", int'(rd_word), 5);
        cfg_read("R3 m unchanged by lone strobes", 9);
        cfg_read("R3 n unchanged by lone strobes", 5);
        // Write pointer must still be at ae; upper din bits must be dropped.
        cfg_write(18'h3F00B);
        cfg_read("R3 R4 m after next write", 9);
        cfg_read("R9 R3 upper din bits discarded, n=11", 11);
        cfg_write(18'd9);
    endtask

    task automatic t_sweep(input logic fwft, input int n, input int m);
        mode_fwft = fwft;
        for (int f = 0; f <= DEPTH; f++) begin
            @(negedge wr_clk);
            fill_level = CNT_W'(f);
            #1;
            check(fwft ? "R7 R10 almost_empty_n fwft" : "R6 R10 almost_empty_n std",
                  int'(almost_empty_n), (f <= n + int'(fwft)) ? 0 : 1);
            check("R8 R10 almost_full_n", int'(almost_full_n),
                  ((DEPTH - f) <= m) ? 0 : 1);
        end
    endtask

    initial begin
        t_reset_state();
        t_load_readback();
        t_ignored_strobes();
        t_sweep(1'b0, 11, 9);
        t_sweep(1'b1, 11, 9);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule